// File: doc/BRIEF.md
# DDR Sub-Channel Performance Monitor

This block keeps the event statistics for one memory sub-channel. It watches the command handshake on the host side of the memory controller, a tagged access strobe, a tagged uncorrectable-error retry strobe and a vector of general controller event strobes. It counts them in saturating counters. Software reads and controls the block over a simple word-addressed register port. Each read returns its data one cycle after the strobe. Bandwidth follows from the counts: each access count stands for one 64-byte transfer, and the cycle counter gives the time base.

The counters form four groups. The first is a 64-bit cycle counter, read as a low word and a high word. The second is a bank of access counters with two modes. In bank-group mode each counter follows one bank group of the rank that software selects. In rank mode only the first four counters are used, one per rank. The third is one retry counter for each uncorrectable-error type. The fourth is a bank of general counters, each with its own event select.

A three-state control machine gates all counting:
- **ST_STOP**: counting is held.
- **ST_RUN**: counting is live.
- **ST_CLEAR**: lasts one cycle and zeroes every counter and flag.

Its transitions are:
- STOP→RUN when the enable bit is written to 1.
- RUN→STOP when the enable bit is written to 0.
- STOP→CLEAR or RUN→CLEAR on any write with the clear bit set.
- CLEAR→RUN or CLEAR→STOP, depending on the enable bit.

Top module: `ddr_subch_perfmon`

## Requirements
- R1: After reset every counter, overflow flag and event select reads 0, and the control word at word address 0x00 reads 0. The control word holds enable in bit 0, clear in bit 1 (reads 0), mode in bit 2 (1 = rank mode) and the selected rank in bits 5:4.
- R2: While the enable bit is 0, no counter changes, including the cycle counter.
- R3: While enabled, the cycle counter advances by one each clock. Reading word 0x01 returns its low 32 bits and copies the high bits into a shadow register. Reading word 0x02 returns that shadow.
- R4: In bank-group mode (mode 0), an access pulse increments access counter i (word 0x08+i) only when its rank tag equals the selected rank and its bank-group tag equals i.
- R5: In rank mode (mode 1), an access pulse with rank tag r increments access counter r (r in 0..3). Access counters 4 to 7 do not change.
- R6: A retry pulse with type t in 0..9 increments retry counter t (word 0x10+t). Types 10 to 15 are ignored.
- R7: Common counter j (word 0x20+j) increments when the event picked by its 4-bit select (word 0x30+j) pulses. The select codes are:
  - 0: none
  - 1: host read accepted (valid and ready with type 0)
  - 2: host write accepted (type 1)
  - 3: host read-modify-write accepted (type 2)
  - 4 to 15: controller event bit (code-4)
- R8: A control write with bit 1 set zeroes all counters and overflow flags at the following clock edge. Events in that clear cycle are lost.
- R9: A counter at all-ones stays there when incremented and sets its sticky overflow flag. The access flags are at word 0x03, the retry flags at 0x04, the common flags at 0x05 and the cycle flag at 0x06 bit 0. Only a clear resets the flags.
- R10: Mode and rank-select bits written while the enable bit is 1 are ignored. The enable and clear bits of that write still act.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Word address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| hif_cmd_valid | input | 1 | Host command valid |
| hif_cmd_ready | input | 1 | Host command accepted by controller |
| hif_cmd_type | input | 2 | 0 read, 1 write, 2 read-modify-write |
| acc_pulse | input | 1 | One 64-byte access strobe |
| acc_rank | input | clog2(NUM_RANK) | Rank tag of the access |
| acc_bg | input | clog2(NUM_BG) | Bank-group tag of the access |
| retry_pulse | input | 1 | Uncorrectable-error retry strobe |
| retry_type | input | clog2(NUM_RETRY) | Error type of the retry |
| ctl_evt | input | NUM_CTL_EVT | General controller event strobes |

## Verification
The assertions check several properties on every cycle:
- Counters and the cycle counter hold still outside ST_RUN.
- ST_CLEAR empties everything on the next edge.
- The cycle counter steps by exactly one while running.
- The shadow captures the high bits on a low-word read.
- Overflow flags never fall without a clear.
- Mode and rank stay frozen while enabled.
- The upper access counters hold in rank mode.

Only the bench's scenarios can show the event routing:
- Which counter a given rank, bank-group, retry type or select code reaches.
- That refused host commands and out-of-range retry types are dropped.
- The exact saturation value.
- That a pulse in the clear cycle is lost.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;

    localparam int ADDR_W = 8;

    typedef enum logic [1:0] {
        ST_STOP  = 2'd0,
        ST_RUN   = 2'd1,
        ST_CLEAR = 2'd2
    } pm_state_e;

    // register word addresses
    localparam logic [ADDR_W-1:0] A_CTRL    = 8'h00;
    localparam logic [ADDR_W-1:0] A_CYC_LO  = 8'h01;
    localparam logic [ADDR_W-1:0] A_CYC_HI  = 8'h02;
    localparam logic [ADDR_W-1:0] A_OVF_ACC = 8'h03;
    localparam logic [ADDR_W-1:0] A_OVF_RTY = 8'h04;
    localparam logic [ADDR_W-1:0] A_OVF_COM = 8'h05;
    localparam logic [ADDR_W-1:0] A_OVF_CYC = 8'h06;
    localparam logic [ADDR_W-1:0] A_ACC     = 8'h08;
    localparam logic [ADDR_W-1:0] A_RTY     = 8'h10;
    localparam logic [ADDR_W-1:0] A_COM     = 8'h20;
    localparam logic [ADDR_W-1:0] A_SEL     = 8'h30;

    // control word bits
    localparam int CTRL_EN   = 0;
    localparam int CTRL_CLR  = 1;
    localparam int CTRL_MODE = 2;
    localparam int CTRL_RANK = 4;

    // common-counter event codes
    localparam int EVT_HIF_RD   = 1;
    localparam int EVT_HIF_WR   = 2;
    localparam int EVT_HIF_RMW  = 3;
    localparam int EVT_CTL_BASE = 4;

    localparam logic [1:0] HIF_RD  = 2'd0;
    localparam logic [1:0] HIF_WR  = 2'd1;
    localparam logic [1:0] HIF_RMW = 2'd2;

endpackage

// File: rtl/perfmon_sat_cnt.sv
module perfmon_sat_cnt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q,
    output logic         ovf
);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            q   <= '0;
            ovf <= 1'b0;
        end else if (inc) begin
            if (q == '1) begin
                ovf <= 1'b1;
            end else begin
                q <= q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/perfmon_ctrl_fsm.sv
module perfmon_ctrl_fsm
    import perfmon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr_req,
    input  logic en_next,
    output logic run,
    output logic clr
);

    pm_state_e state_q;
    pm_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP: begin
                if (clr_req)      state_d = ST_CLEAR;
                else if (en_next) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (clr_req)       state_d = ST_CLEAR;
                else if (!en_next) state_d = ST_STOP;
            end
            ST_CLEAR: begin
                if (clr_req)      state_d = ST_CLEAR;
                else if (en_next) state_d = ST_RUN;
                else              state_d = ST_STOP;
            end
            default: state_d = ST_STOP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_STOP;
        else        state_q <= state_d;
    end

    always_comb begin
        run = 1'b0;
        clr = 1'b0;
        unique case (state_q)
            ST_STOP:  ;
            ST_RUN:   run = 1'b1;
            ST_CLEAR: clr = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/perfmon_evt_route.sv
module perfmon_evt_route
    import perfmon_pkg::*;
#(
    parameter int NUM_RANK    = 4,
    parameter int NUM_BG      = 8,
    parameter int NUM_RETRY   = 10,
    parameter int NUM_COM     = 16,
    parameter int NUM_CTL_EVT = 12,
    parameter int RANK_W      = 2,
    parameter int BG_W        = 3,
    parameter int RTY_W       = 4,
    parameter int SEL_W       = 4
) (
    input  logic                            run,
    input  logic                            mode_rank,
    input  logic [RANK_W-1:0]               rank_sel,
    input  logic                            acc_pulse,
    input  logic [RANK_W-1:0]               acc_rank,
    input  logic [BG_W-1:0]                 acc_bg,
    input  logic                            retry_pulse,
    input  logic [RTY_W-1:0]                retry_type,
    input  logic                            hif_valid,
    input  logic                            hif_ready,
    input  logic [1:0]                      hif_type,
    input  logic [NUM_CTL_EVT-1:0]          ctl_evt,
    input  logic [NUM_COM-1:0][SEL_W-1:0]   sel,
    output logic [NUM_BG-1:0]               acc_inc,
    output logic [NUM_RETRY-1:0]            rty_inc,
    output logic [NUM_COM-1:0]              com_inc
);

    localparam int EVT_SPACE = 2 ** SEL_W;

    logic                 hif_fire;
    logic [EVT_SPACE-1:0] evt_vec;

    always_comb begin
        hif_fire = hif_valid && hif_ready;
        evt_vec  = '0;
        evt_vec[EVT_HIF_RD]  = hif_fire && (hif_type == HIF_RD);
        evt_vec[EVT_HIF_WR]  = hif_fire && (hif_type == HIF_WR);
        evt_vec[EVT_HIF_RMW] = hif_fire && (hif_type == HIF_RMW);
        evt_vec[EVT_CTL_BASE +: NUM_CTL_EVT] = ctl_evt;
    end

    for (genvar gi = 0; gi < NUM_BG; gi++) begin : g_acc
        logic bg_hit;
        logic rank_hit;
        assign bg_hit = (acc_rank == rank_sel) && (acc_bg == BG_W'(gi));
        if (gi < NUM_RANK) begin : g_rank
            assign rank_hit = (acc_rank == RANK_W'(gi));
        end else begin : g_norank
            assign rank_hit = 1'b0;
        end
        assign acc_inc[gi] = run && acc_pulse && (mode_rank ? rank_hit : bg_hit);
    end

    for (genvar gi = 0; gi < NUM_RETRY; gi++) begin : g_rty
        assign rty_inc[gi] = run && retry_pulse && (retry_type == RTY_W'(gi));
    end

    for (genvar gi = 0; gi < NUM_COM; gi++) begin : g_com
        assign com_inc[gi] = run && evt_vec[sel[gi]];
    end

endmodule

// File: rtl/ddr_subch_perfmon.sv
module ddr_subch_perfmon
    import perfmon_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int CNT_W       = 32,
    parameter int CYC_W       = 64,
    parameter int NUM_RANK    = 4,
    parameter int NUM_BG      = 8,
    parameter int NUM_RETRY   = 10,
    parameter int NUM_COM     = 16,
    parameter int NUM_CTL_EVT = 12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_wr,
    input  logic                          reg_rd,
    input  logic [7:0]                    reg_addr,
    input  logic [DATA_W-1:0]             reg_wdata,
    output logic [DATA_W-1:0]             reg_rdata,
    output logic                          reg_rvalid,
    input  logic                          hif_cmd_valid,
    input  logic                          hif_cmd_ready,
    input  logic [1:0]                    hif_cmd_type,
    input  logic                          acc_pulse,
    input  logic [$clog2(NUM_RANK)-1:0]   acc_rank,
    input  logic [$clog2(NUM_BG)-1:0]     acc_bg,
    input  logic                          retry_pulse,
    input  logic [$clog2(NUM_RETRY)-1:0]  retry_type,
    input  logic [NUM_CTL_EVT-1:0]        ctl_evt
);

    localparam int RANK_W   = $clog2(NUM_RANK);
    localparam int BG_W     = $clog2(NUM_BG);
    localparam int RTY_W    = $clog2(NUM_RETRY);
    localparam int NUM_EVT  = EVT_CTL_BASE + NUM_CTL_EVT;
    localparam int SEL_W    = $clog2(NUM_EVT);
    localparam int NUM_ACC  = NUM_BG;
    localparam int CYC_HI_W = CYC_W - DATA_W;
    localparam int NUM_ALL  = NUM_ACC + NUM_RETRY + NUM_COM;
    localparam int NUM_OVF  = NUM_ALL + 1;

    // control state
    logic              en_q;
    logic              mode_q;
    logic [RANK_W-1:0] rank_q;
    logic              wr_ctrl;
    logic              clr_req;
    logic              en_next;
    logic              run;
    logic              clr;

    logic [NUM_COM-1:0][SEL_W-1:0] sel_q;

    // counter values and flags
    logic [CYC_W-1:0]                cyc_q;
    logic                            cyc_ovf;
    logic [CYC_HI_W-1:0]             cyc_shadow;
    logic [NUM_ACC-1:0][CNT_W-1:0]   acc_val;
    logic [NUM_RETRY-1:0][CNT_W-1:0] rty_val;
    logic [NUM_COM-1:0][CNT_W-1:0]   com_val;
    logic [NUM_ACC-1:0]              acc_ovf;
    logic [NUM_RETRY-1:0]            rty_ovf;
    logic [NUM_COM-1:0]              com_ovf;
    logic [NUM_ACC-1:0]              acc_inc;
    logic [NUM_RETRY-1:0]            rty_inc;
    logic [NUM_COM-1:0]              com_inc;

    // flattened views for the bound checker
    logic [NUM_ALL*CNT_W-1:0]        cnt_all;
    logic [NUM_OVF-1:0]              ovf_all;
    assign cnt_all = {com_val, rty_val, acc_val};
    assign ovf_all = {cyc_ovf, com_ovf, rty_ovf, acc_ovf};

    assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
    assign clr_req = wr_ctrl && reg_wdata[CTRL_CLR];
    assign en_next = wr_ctrl ? reg_wdata[CTRL_EN] : en_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            mode_q <= 1'b0;
            rank_q <= '0;
        end else begin
            en_q <= en_next;
            if (wr_ctrl && !en_q) begin
                mode_q <= reg_wdata[CTRL_MODE];
                rank_q <= reg_wdata[CTRL_RANK +: RANK_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else begin
            for (int j = 0; j < NUM_COM; j++) begin
                if (reg_wr && (reg_addr == A_SEL + ADDR_W'(j))) begin
                    sel_q[j] <= reg_wdata[SEL_W-1:0];
                end
            end
        end
    end

    perfmon_ctrl_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_req (clr_req),
        .en_next (en_next),
        .run     (run),
        .clr     (clr)
    );

    perfmon_evt_route #(
        .NUM_RANK    (NUM_RANK),
        .NUM_BG      (NUM_BG),
        .NUM_RETRY   (NUM_RETRY),
        .NUM_COM     (NUM_COM),
        .NUM_CTL_EVT (NUM_CTL_EVT),
        .RANK_W      (RANK_W),
        .BG_W        (BG_W),
        .RTY_W       (RTY_W),
        .SEL_W       (SEL_W)
    ) u_route (
        .run         (run),
        .mode_rank   (mode_q),
        .rank_sel    (rank_q),
        .acc_pulse   (acc_pulse),
        .acc_rank    (acc_rank),
        .acc_bg      (acc_bg),
        .retry_pulse (retry_pulse),
        .retry_type  (retry_type),
        .hif_valid   (hif_cmd_valid),
        .hif_ready   (hif_cmd_ready),
        .hif_type    (hif_cmd_type),
        .ctl_evt     (ctl_evt),
        .sel         (sel_q),
        .acc_inc     (acc_inc),
        .rty_inc     (rty_inc),
        .com_inc     (com_inc)
    );

    perfmon_sat_cnt #(.W(CYC_W)) u_cyc (
        .clk (clk), .rst_n (rst_n), .clr (clr), .inc (run),
        .q   (cyc_q), .ovf (cyc_ovf)
    );

    for (genvar gi = 0; gi < NUM_ACC; gi++) begin : g_acc_cnt
        perfmon_sat_cnt #(.W(CNT_W)) u_cnt (
            .clk (clk), .rst_n (rst_n), .clr (clr), .inc (acc_inc[gi]),
            .q   (acc_val[gi]), .ovf (acc_ovf[gi])
        );
    end

    for (genvar gi = 0; gi < NUM_RETRY; gi++) begin : g_rty_cnt
        perfmon_sat_cnt #(.W(CNT_W)) u_cnt (
            .clk (clk), .rst_n (rst_n), .clr (clr), .inc (rty_inc[gi]),
            .q   (rty_val[gi]), .ovf (rty_ovf[gi])
        );
    end

    for (genvar gi = 0; gi < NUM_COM; gi++) begin : g_com_cnt
        perfmon_sat_cnt #(.W(CNT_W)) u_cnt (
            .clk (clk), .rst_n (rst_n), .clr (clr), .inc (com_inc[gi]),
            .q   (com_val[gi]), .ovf (com_ovf[gi])
        );
    end

    // high cycle word captured when the low word is read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_shadow <= '0;
        end else if (reg_rd && (reg_addr == A_CYC_LO)) begin
            cyc_shadow <= cyc_q[CYC_W-1:DATA_W];
        end
    end

    logic [DATA_W-1:0] rd_mux;

    always_comb begin
        rd_mux = '0;
        if (reg_addr == A_CTRL) begin
            rd_mux[CTRL_EN]             = en_q;
            rd_mux[CTRL_MODE]           = mode_q;
            rd_mux[CTRL_RANK +: RANK_W] = rank_q;
        end
        if (reg_addr == A_CYC_LO)  rd_mux = cyc_q[DATA_W-1:0];
        if (reg_addr == A_CYC_HI)  rd_mux = DATA_W'(cyc_shadow);
        if (reg_addr == A_OVF_ACC) rd_mux = DATA_W'(acc_ovf);
        if (reg_addr == A_OVF_RTY) rd_mux = DATA_W'(rty_ovf);
        if (reg_addr == A_OVF_COM) rd_mux = DATA_W'(com_ovf);
        if (reg_addr == A_OVF_CYC) rd_mux = DATA_W'(cyc_ovf);
        for (int i = 0; i < NUM_ACC; i++) begin
            if (reg_addr == A_ACC + ADDR_W'(i)) rd_mux = DATA_W'(acc_val[i]);
        end
        for (int i = 0; i < NUM_RETRY; i++) begin
            if (reg_addr == A_RTY + ADDR_W'(i)) rd_mux = DATA_W'(rty_val[i]);
        end
        for (int i = 0; i < NUM_COM; i++) begin
            if (reg_addr == A_COM + ADDR_W'(i)) rd_mux = DATA_W'(com_val[i]);
            if (reg_addr == A_SEL + ADDR_W'(i)) rd_mux = DATA_W'(sel_q[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata  <= '0;
            reg_rvalid <= 1'b0;
        end else begin
            reg_rvalid <= reg_rd;
            if (reg_rd) reg_rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/perfmon_checker.sv
module perfmon_checker
    import perfmon_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int CNT_W    = 32,
    parameter int CYC_W    = 64,
    parameter int NUM_ACC  = 8,
    parameter int NUM_RANK = 4,
    parameter int NUM_ALL  = 34,
    parameter int NUM_OVF  = 35,
    parameter int RANK_W   = 2
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        run,
    input logic                        clr,
    input logic                        en_q,
    input logic                        mode_q,
    input logic [RANK_W-1:0]           rank_q,
    input logic [NUM_ALL*CNT_W-1:0]    cnt_all,
    input logic [NUM_OVF-1:0]          ovf_all,
    input logic [CYC_W-1:0]            cyc_q,
    input logic [CYC_W-DATA_W-1:0]     cyc_shadow,
    input logic                        reg_rd,
    input logic [ADDR_W-1:0]           reg_addr
);

    assert_state_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(run && clr));

    assert_stopped_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> ($stable(cnt_all) && $stable(cyc_q)));

    assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_all == '0 && cyc_q == '0 && ovf_all == '0));

    assert_cycle_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cyc_q != '1) |=> (cyc_q == $past(cyc_q) + 1'b1));

    assert_shadow_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_CYC_LO) |=> (cyc_shadow == $past(cyc_q[CYC_W-1:DATA_W])));

    assert_upper_acc_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && mode_q) |=> $stable(cnt_all[NUM_ACC*CNT_W-1:NUM_RANK*CNT_W]));

    assert_mode_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |=> ($stable(mode_q) && $stable(rank_q)));

    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((ovf_all & $past(ovf_all)) == $past(ovf_all)));

endmodule

bind ddr_subch_perfmon perfmon_checker #(
    .DATA_W   (DATA_W),
    .CNT_W    (CNT_W),
    .CYC_W    (CYC_W),
    .NUM_ACC  (NUM_ACC),
    .NUM_RANK (NUM_RANK),
    .NUM_ALL  (NUM_ALL),
    .NUM_OVF  (NUM_OVF),
    .RANK_W   (RANK_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .clr        (clr),
    .en_q       (en_q),
    .mode_q     (mode_q),
    .rank_q     (rank_q),
    .cnt_all    (cnt_all),
    .ovf_all    (ovf_all),
    .cyc_q      (cyc_q),
    .cyc_shadow (cyc_shadow),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr)
);

// File: tb/ddr_subch_perfmon_test.sv
module ddr_subch_perfmon_test;

    localparam int CLK_PERIOD = 10;
    localparam int TB_CNT_W   = 4;   // small counters so saturation is reachable

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr, reg_rd;
    logic [7:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        reg_rvalid;
    logic        hif_cmd_valid, hif_cmd_ready;
    logic [1:0]  hif_cmd_type;
    logic        acc_pulse;
    logic [1:0]  acc_rank;
    logic [2:0]  acc_bg;
    logic        retry_pulse;
    logic [3:0]  retry_type;
    logic [11:0] ctl_evt;

    always #(CLK_PERIOD/2) clk = ~clk;

    ddr_subch_perfmon #(.CNT_W(TB_CNT_W)) uut (
        .clk (clk), .rst_n (rst_n),
        .reg_wr (reg_wr), .reg_rd (reg_rd), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .reg_rvalid (reg_rvalid),
        .hif_cmd_valid (hif_cmd_valid), .hif_cmd_ready (hif_cmd_ready),
        .hif_cmd_type (hif_cmd_type),
        .acc_pulse (acc_pulse), .acc_rank (acc_rank), .acc_bg (acc_bg),
        .retry_pulse (retry_pulse), .retry_type (retry_type),
        .ctl_evt (ctl_evt)
    );

    int n_checks = 0;
    int n_errors = 0;

    logic [31:0] exp_q [$];
    string       tag_q [$];
    bit          cmp_q [$];
    logic [31:0] last_rd;

    function automatic void check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endfunction

    // monitor: pops the scoreboard on every returned read
    always @(negedge clk) begin
        if (rst_n === 1'b1 && reg_rvalid === 1'b1) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "unexpected read data", reg_rdata, 32'h0);
            end else begin
                logic [31:0] e;
                string       t;
                bit          c;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                c = cmp_q.pop_front();
                if (c) check(reg_rdata === e, t, reg_rdata, e);
                else   last_rd = reg_rdata;
            end
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(logic [7:0] a, logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(logic [7:0] a);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic expect_rd(logic [7:0] a, logic [31:0] e, string t);
        exp_q.push_back(e); tag_q.push_back(t); cmp_q.push_back(1'b1);
        reg_read(a);
    endtask

    task automatic capture_rd(logic [7:0] a, output logic [31:0] v);
        exp_q.push_back(32'h0); tag_q.push_back("capture"); cmp_q.push_back(1'b0);
        reg_read(a);
        #1;
        v = last_rd;
    endtask

    task automatic acc_evt(logic [1:0] r, logic [2:0] bg, int n);
        for (int k = 0; k < n; k++) begin
            acc_pulse = 1'b1; acc_rank = r; acc_bg = bg;
            @(negedge clk);
            acc_pulse = 1'b0;
        end
    endtask

    task automatic retry_evt(logic [3:0] t, int n);
        for (int k = 0; k < n; k++) begin
            retry_pulse = 1'b1; retry_type = t;
            @(negedge clk);
            retry_pulse = 1'b0;
        end
    endtask

    task automatic hif_evt(logic [1:0] t, logic rdy, int n);
        for (int k = 0; k < n; k++) begin
            hif_cmd_valid = 1'b1; hif_cmd_ready = rdy; hif_cmd_type = t;
            @(negedge clk);
            hif_cmd_valid = 1'b0; hif_cmd_ready = 1'b0;
        end
    endtask

    task automatic ctl_pulse(int bitn, int n);
        for (int k = 0; k < n; k++) begin
            ctl_evt = 12'h0; ctl_evt[bitn] = 1'b1;
            @(negedge clk);
            ctl_evt = 12'h0;
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] v1, v2;
        rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = 8'h0; reg_wdata = 32'h0;
        hif_cmd_valid = 1'b0; hif_cmd_ready = 1'b0; hif_cmd_type = 2'd3;
        acc_pulse = 1'b0; acc_rank = 2'd0; acc_bg = 3'd0;
        retry_pulse = 1'b0; retry_type = 4'd0; ctl_evt = 12'h0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        expect_rd(8'h00, 32'h0, "R1 ctrl");
        expect_rd(8'h08, 32'h0, "R1 acc0");
        expect_rd(8'h10, 32'h0, "R1 rty0");
        expect_rd(8'h20, 32'h0, "R1 com0");
        expect_rd(8'h30, 32'h0, "R1 sel0");
        expect_rd(8'h03, 32'h0, "R1 ovf acc");
        expect_rd(8'h01, 32'h0, "R1 cycle lo");

        // R2 disabled: nothing counts
        acc_evt(2'd0, 3'd0, 2);
        retry_evt(4'd0, 1);
        expect_rd(8'h08, 32'h0, "R2 acc0 disabled");
        expect_rd(8'h10, 32'h0, "R2 rty0 disabled");
        expect_rd(8'h01, 32'h0, "R2 cycle disabled");

        // R4 bank-group mode, rank 1 selected, then enable
        reg_write(8'h00, 32'h10);
        reg_write(8'h00, 32'h11);
        acc_evt(2'd1, 3'd3, 3);
        acc_evt(2'd1, 3'd0, 1);
        acc_evt(2'd0, 3'd3, 2);
        acc_evt(2'd2, 3'd5, 1);
        expect_rd(8'h0B, 32'd3, "R4 acc3 rank1 bg3");
        expect_rd(8'h08, 32'd1, "R4 acc0 rank1 bg0");
        expect_rd(8'h0D, 32'd0, "R4 acc5 other rank");

        // R10 mode/rank write ignored while enabled
        reg_write(8'h00, 32'h25);
        expect_rd(8'h00, 32'h11, "R10 ctrl unchanged");
        acc_evt(2'd1, 3'd3, 1);
        expect_rd(8'h0B, 32'd4, "R10 still bank-group rank1");

        // R3 cycle counter step and shadow
        capture_rd(8'h01, v1);
        idle(5);
        capture_rd(8'h01, v2);
        check((v2 - v1) == 32'd6, "R3 cycle delta", v2 - v1, 32'd6);
        expect_rd(8'h02, 32'h0, "R3 high shadow");

        // R6 retry counters
        retry_evt(4'd0, 2);
        retry_evt(4'd9, 1);
        retry_evt(4'd10, 1);
        retry_evt(4'd15, 1);
        expect_rd(8'h10, 32'd2, "R6 rty0");
        expect_rd(8'h19, 32'd1, "R6 rty9");
        for (int i = 1; i < 9; i++) expect_rd(8'h10 + 8'(i), 32'd0, "R6 untouched rty");

        // R7 common counters with selects
        reg_write(8'h30, 32'd1);
        reg_write(8'h31, 32'd2);
        reg_write(8'h32, 32'd3);
        reg_write(8'h33, 32'd4);
        reg_write(8'h34, 32'd15);
        expect_rd(8'h34, 32'd15, "R7 sel4 readback");
        hif_evt(2'd0, 1'b1, 2);
        hif_evt(2'd0, 1'b0, 1);
        hif_evt(2'd1, 1'b1, 1);
        hif_evt(2'd2, 1'b1, 3);
        hif_evt(2'd3, 1'b1, 1);
        ctl_pulse(0, 1);
        ctl_pulse(11, 2);
        expect_rd(8'h20, 32'd2, "R7 host reads");
        expect_rd(8'h21, 32'd1, "R7 host writes");
        expect_rd(8'h22, 32'd3, "R7 host rmw");
        expect_rd(8'h23, 32'd1, "R7 ctl evt0");
        expect_rd(8'h24, 32'd2, "R7 ctl evt11");
        expect_rd(8'h25, 32'd0, "R7 select none");

        // R9 saturation and sticky flag
        acc_evt(2'd1, 3'd3, 13);
        expect_rd(8'h0B, 32'd15, "R9 saturated acc3");
        expect_rd(8'h03, 32'h08, "R9 acc overflow flag");
        expect_rd(8'h05, 32'h0, "R9 common no overflow");
        idle(3);
        expect_rd(8'h03, 32'h08, "R9 flag sticky");

        // R8 clear; a pulse in the clear cycle is lost
        reg_write(8'h00, 32'h13);
        acc_evt(2'd1, 3'd3, 1);
        expect_rd(8'h0B, 32'd0, "R8 acc3 cleared");
        expect_rd(8'h03, 32'h0, "R8 ovf cleared");
        expect_rd(8'h22, 32'd0, "R8 com2 cleared");
        expect_rd(8'h10, 32'd0, "R8 rty0 cleared");
        expect_rd(8'h00, 32'h11, "R8 ctrl after clear");

        // R5 rank mode
        acc_evt(2'd1, 3'd5, 1);
        reg_write(8'h00, 32'h10);
        reg_write(8'h00, 32'h14);
        reg_write(8'h00, 32'h15);
        expect_rd(8'h00, 32'h15, "R5 ctrl rank mode");
        acc_evt(2'd0, 3'd7, 1);
        acc_evt(2'd3, 3'd2, 2);
        acc_evt(2'd2, 3'd0, 1);
        acc_evt(2'd1, 3'd5, 1);
        acc_evt(2'd3, 3'd5, 1);
        expect_rd(8'h08, 32'd1, "R5 rank0");
        expect_rd(8'h09, 32'd1, "R5 rank1");
        expect_rd(8'h0A, 32'd1, "R5 rank2");
        expect_rd(8'h0B, 32'd3, "R5 rank3");
        expect_rd(8'h0C, 32'd0, "R5 acc4 unchanged");
        expect_rd(8'h0D, 32'd1, "R5 acc5 unchanged");
        expect_rd(8'h0F, 32'd0, "R5 acc7 unchanged");

        // R2 cycle frozen once disabled
        reg_write(8'h00, 32'h14);
        capture_rd(8'h01, v1);
        idle(3);
        capture_rd(8'h01, v2);
        check(v1 == v2, "R2 cycle frozen", v2, v1);

        idle(3);
        check(exp_q.size() == 0, "scoreboard drained", 32'(exp_q.size()), 32'h0);
        finish_run();
    end

endmodule